// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block sits on the host side of a multichannel simultaneous-sampling SAR converter with a parallel result bus. When it accepts a start request it drives the active-low conversion-start strobe low for an acquisition window. The rising edge of that strobe begins conversion on every channel at once. The controller then waits for the converter's end-of-conversion flag to fall. After that it issues one active-low read strobe per channel, with chip-select asserted, and latches the bus during each read-low phase. Each result leaves the block as a one-cycle valid pulse that carries the channel index.

Two start styles are supported and chosen per frame by the `long_acq` input, which is sampled together with `start`. The long style holds the strobe low for the full tracking time. The short style gives only the minimum valid pulse, for a converter that tracks on its own between conversions. All timing is set in nanoseconds and converted to clock cycles from the clock period parameter. The `CS_PER_FRAME` parameter chooses whether chip-select stays low across the whole readout or returns high between channels. `adc_eoc` and `adc_d` are taken to be synchronous to `clk`.

The state machine has eight states: IDLE, ACQ (strobe low), ARM (strobe high, flag not yet trusted), WAIT (watch for the flag to fall), RDLO (read low), RDHI (gap between reads), FIN (frame done) and ERR (timeout). Its transitions are: IDLE to ACQ on start, ACQ to ARM, ARM to WAIT, WAIT to RDLO or to ERR, RDLO to RDHI or to FIN, RDHI to RDLO, and FIN or ERR to IDLE.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters IDLE. After that edge `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are 1, and `busy`, `res_valid`, `frame_done` and `timeout_err` are 0.
- R2: A start accepted in IDLE with `long_acq`=1 drives `adc_convst_n` low for exactly ceil(ACQ_NS/CLK_NS) cycles, beginning the cycle after acceptance.
- R3: With `long_acq`=0 the low window lasts exactly ceil(PULSE_NS/CLK_NS) cycles (at least 1).
- R4: After the strobe rises, `adc_eoc` is ignored for ARM_CYC cycles. From then on, the first clock edge that sees `adc_eoc`=0 starts the readout in the next cycle.
- R5: A frame has exactly NUM_CH read-low periods of ceil(RDLO_NS/CLK_NS) cycles each, separated by high periods of ceil(RDHI_NS/CLK_NS) cycles.
- R6: `adc_cs_n` is 0 whenever `adc_rd_n` is 0. Between reads it stays 0 when CS_PER_FRAME=1 and returns to 1 when CS_PER_FRAME=0. It is 1 outside the readout.
- R7: The bus is captured at the clock edge that ends cycle SAMPLE_OFS (counted from 0) of each read-low period. In the following cycle `res_valid` is 1 for one cycle, with `res_data` equal to the captured value and `res_ch` equal to the channel number: 0 for the first read, rising by 1 for each read after it.
- R8: `frame_done` is a one-cycle pulse in the cycle right after the last read-low period, with all strobes high. `busy` is 0 in the next cycle.
- R9: `busy` is 1 from the cycle after acceptance until the cycle after FIN or ERR. A `start` seen while `busy` is 1 has no effect.
- R10: If `adc_eoc` is still 1 at the TIMEOUT_CYC-th edge in WAIT, `timeout_err` pulses for one cycle, no read strobe is issued, and the block returns to IDLE.
- R11: If `adc_eoc` is seen low at the very edge on which the timeout would expire, the readout proceeds and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion frame (accepted in IDLE only) |
| long_acq | input | 1 | Start style for the accepted frame: 1 long window, 0 short pulse |
| adc_eoc | input | 1 | Converter end-of-conversion flag, high while converting |
| adc_d | input | DW | Converter parallel result bus |
| adc_convst_n | output | 1 | Conversion-start strobe, active low |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| res_valid | output | 1 | One-cycle result valid |
| res_ch | output | CHW | Channel index of the result |
| res_data | output | DW | Captured result |
| frame_done | output | 1 | One-cycle pulse after the last channel |
| timeout_err | output | 1 | One-cycle pulse when the conversion flag never fell |
| busy | output | 1 | Frame in progress |

## Verification
The end-of-conversion flag falling and the WAIT timeout expiring can land on the same clock edge. By requirement R11 the flag wins. The bench sweeps the converter model's conversion length across that boundary, one cycle at a time, so that some frames fall just before the limit, one falls exactly on it, and others fall past it. On every clock its behavioural model decides from the flag value it sees at each edge whether reads or an error pulse must follow. It also checks, at every cycle, whether a start pulse held on the frame-done cycle or repeated during a readout is ignored or accepted.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_ARM,
        ST_WAIT,
        ST_RDLO,
        ST_RDHI,
        ST_FIN,
        ST_ERR
    } rd_state_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_rd_timer.sv
module sar_rd_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R5: an idle timer parks at zero instead of wrapping
    a_r5_timer_parks: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/sar_rd_chan_cnt.sv
module sar_rd_chan_cnt #(
    parameter int NUM_CH = 6,
    parameter int CHW    = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           step,
    output logic [CHW-1:0] idx,
    output logic           last
);

    localparam logic [CHW-1:0] LAST_IDX = CHW'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            idx <= '0;
        else if (step && idx != LAST_IDX)
            idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

    a_r7_chan_in_range: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);

endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
    parameter int DW  = 16,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           grab,
    input  logic [DW-1:0]  bus,
    input  logic [CHW-1:0] ch_in,
    output logic           valid,
    output logic [DW-1:0]  data,
    output logic [CHW-1:0] ch_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            data   <= '0;
            ch_out <= '0;
        end else begin
            valid <= grab;
            if (grab) begin
                data   <= bus;
                ch_out <= ch_in;
            end
        end
    end

endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_rd_pkg::*;
#(
    parameter int NUM_CH       = 6,
    parameter int DW           = 16,
    parameter int CLK_NS       = 10,
    parameter int ACQ_NS       = 1000,
    parameter int PULSE_NS     = 20,
    parameter int RDLO_NS      = 30,
    parameter int RDHI_NS      = 30,
    parameter int ARM_CYC      = 3,
    parameter int TIMEOUT_CYC  = 400,
    parameter int SAMPLE_OFS   = 1,
    parameter bit CS_PER_FRAME = 1'b1,
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           long_acq,
    input  logic           adc_eoc,
    input  logic [DW-1:0]  adc_d,
    output logic           adc_convst_n,
    output logic           adc_cs_n,
    output logic           adc_rd_n,
    output logic           res_valid,
    output logic [CHW-1:0] res_ch,
    output logic [DW-1:0]  res_data,
    output logic           frame_done,
    output logic           timeout_err,
    output logic           busy
);

    // Phase lengths in cycles; SAMPLE_OFS must stay below RDLO_C
    localparam int ACQ_C  = ns_to_cyc(ACQ_NS, CLK_NS);
    localparam int PUL_C  = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int RDLO_C = ns_to_cyc(RDLO_NS, CLK_NS);
    localparam int RDHI_C = ns_to_cyc(RDHI_NS, CLK_NS);
    localparam int MAXC   = imax(imax(imax(ACQ_C, PUL_C), imax(RDLO_C, RDHI_C)),
                                 imax(ARM_CYC, TIMEOUT_CYC));
    localparam int CW     = $clog2(MAXC + 1);

    localparam logic [CW-1:0] LD_ACQ  = CW'(ACQ_C - 1);
    localparam logic [CW-1:0] LD_PUL  = CW'(PUL_C - 1);
    localparam logic [CW-1:0] LD_ARM  = CW'(ARM_CYC - 1);
    localparam logic [CW-1:0] LD_TO   = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] LD_RDLO = CW'(RDLO_C - 1);
    localparam logic [CW-1:0] LD_RDHI = CW'(RDHI_C - 1);
    localparam logic [CW-1:0] GRAB_AT = CW'(RDLO_C - 1 - SAMPLE_OFS);

    rd_state_t st, st_nxt;

    logic          tm_load, tm_zero;
    logic [CW-1:0] tm_val, tm_count;
    logic          ch_clear, ch_step, ch_last;
    logic [CHW-1:0] ch_idx;
    logic          grab;

    sar_rd_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero),
        .count    (tm_count)
    );

    sar_rd_chan_cnt #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .clear (ch_clear),
        .step  (ch_step),
        .idx   (ch_idx),
        .last  (ch_last)
    );

    sar_rd_capture #(.DW(DW), .CHW(CHW)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .grab   (grab),
        .bus    (adc_d),
        .ch_in  (ch_idx),
        .valid  (res_valid),
        .data   (res_data),
        .ch_out (res_ch)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    // Next state and timer / channel control
    always_comb begin
        st_nxt   = st;
        tm_load  = 1'b0;
        tm_val   = '0;
        ch_clear = 1'b0;
        ch_step  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    st_nxt  = ST_ACQ;
                    tm_load = 1'b1;
                    tm_val  = long_acq ? LD_ACQ : LD_PUL;
                end
            end
            ST_ACQ: begin
                if (tm_zero) begin
                    st_nxt  = ST_ARM;
                    tm_load = 1'b1;
                    tm_val  = LD_ARM;
                end
            end
            ST_ARM: begin
                if (tm_zero) begin
                    st_nxt  = ST_WAIT;
                    tm_load = 1'b1;
                    tm_val  = LD_TO;
                end
            end
            ST_WAIT: begin
                if (!adc_eoc) begin
                    st_nxt   = ST_RDLO;
                    tm_load  = 1'b1;
                    tm_val   = LD_RDLO;
                    ch_clear = 1'b1;
                end else if (tm_zero) begin
                    st_nxt = ST_ERR;
                end
            end
            ST_RDLO: begin
                if (tm_zero) begin
                    if (ch_last) begin
                        st_nxt = ST_FIN;
                    end else begin
                        st_nxt  = ST_RDHI;
                        tm_load = 1'b1;
                        tm_val  = LD_RDHI;
                    end
                end
            end
            ST_RDHI: begin
                if (tm_zero) begin
                    st_nxt  = ST_RDLO;
                    tm_load = 1'b1;
                    tm_val  = LD_RDLO;
                    ch_step = 1'b1;
                end
            end
            ST_FIN:  st_nxt = ST_IDLE;
            ST_ERR:  st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign grab = (st == ST_RDLO) && (tm_count == GRAB_AT);

    // Outputs decoded from the state register
    always_comb begin
        adc_convst_n = 1'b1;
        adc_cs_n     = 1'b1;
        adc_rd_n     = 1'b1;
        frame_done   = 1'b0;
        timeout_err  = 1'b0;
        busy         = (st != ST_IDLE);
        unique case (st)
            ST_ACQ:  adc_convst_n = 1'b0;
            ST_RDLO: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            ST_RDHI: adc_cs_n = !CS_PER_FRAME;
            ST_FIN:  frame_done  = 1'b1;
            ST_ERR:  timeout_err = 1'b1;
            default: ;
        endcase
    end

    // Run length of the start strobe low window, for the width check
    logic [CW-1:0] cv_low_run;
    always_ff @(posedge clk) begin
        if (rst)
            cv_low_run <= '0;
        else if (adc_convst_n)
            cv_low_run <= '0;
        else if (cv_low_run != '1)
            cv_low_run <= cv_low_run + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (adc_convst_n && adc_cs_n && adc_rd_n && !busy && !res_valid));

    a_r3_convst_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_convst_n) |-> (cv_low_run >= CW'(PUL_C)));

    a_r6_read_needs_select: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !adc_cs_n);

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!busy && adc_cs_n && adc_rd_n));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_done && !timeout_err) |=> busy);

    a_r10_err_then_idle: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !busy);

    a_r10_no_read_on_error: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (adc_rd_n && adc_cs_n && !frame_done));

endmodule

// File: tb/sar_readout_ctrl_test.sv
module sar_readout_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int ACQ_C = 6;   // 60 ns
    localparam int PUL_C = 2;   // 20 ns
    localparam int RDLO_C = 3;  // 30 ns
    localparam int RDHI_C = 3;  // 25 ns
    localparam int ARM_C = 3;
    localparam int TO_C  = 20;
    localparam int SOFS  = 1;

    logic clk = 1'b0;
    logic rst, start, long_acq, eoc;
    logic [15:0] bus;
    logic cv_n, cs_n, rd_n, vld, done, err, bsy;
    logic [1:0] ch;
    logic [15:0] dat;
    logic cv2, cs2, rd2, vld2, done2, err2, bsy2;
    logic [1:0] ch2;
    logic [15:0] dat2;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_readout_ctrl #(.NUM_CH(NCH), .DW(16), .CLK_NS(10), .ACQ_NS(60), .PULSE_NS(20),
        .RDLO_NS(30), .RDHI_NS(25), .ARM_CYC(ARM_C), .TIMEOUT_CYC(TO_C),
        .SAMPLE_OFS(SOFS), .CS_PER_FRAME(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start), .long_acq(long_acq), .adc_eoc(eoc),
        .adc_d(bus), .adc_convst_n(cv_n), .adc_cs_n(cs_n), .adc_rd_n(rd_n),
        .res_valid(vld), .res_ch(ch), .res_data(dat), .frame_done(done),
        .timeout_err(err), .busy(bsy));

    sar_readout_ctrl #(.NUM_CH(NCH), .DW(16), .CLK_NS(10), .ACQ_NS(60), .PULSE_NS(20),
        .RDLO_NS(30), .RDHI_NS(25), .ARM_CYC(ARM_C), .TIMEOUT_CYC(TO_C),
        .SAMPLE_OFS(SOFS), .CS_PER_FRAME(1'b0)) uut2 (
        .clk(clk), .rst(rst), .start(start), .long_acq(long_acq), .adc_eoc(eoc),
        .adc_d(bus), .adc_convst_n(cv2), .adc_cs_n(cs2), .adc_rd_n(rd2),
        .res_valid(vld2), .res_ch(ch2), .res_data(dat2), .frame_done(done2),
        .timeout_err(err2), .busy(bsy2));

    function automatic logic [15:0] smp(input int fr, input int c);
        return 16'(fr * 4099 + c * 257 + 16'h00A5);
    endfunction

    // Converter model
    int adc_fr = 0, rd_idx = 0, conv_len = 4, ecnt = 0;
    logic prev_cv = 1'b1, prev_rd = 1'b1;
    assign bus = (!cs_n && !rd_n) ? smp(adc_fr, rd_idx) : 16'hzzzz;

    initial eoc = 1'b0;
    always @(negedge clk) begin
        if (cv_n && !prev_cv) begin
            eoc = 1'b1;
            ecnt = conv_len;
            adc_fr++;
            rd_idx = 0;
        end else if (eoc) begin
            if (ecnt <= 1) eoc = 1'b0;
            else ecnt--;
        end
        if (rd_n && !prev_rd) rd_idx++;
        prev_cv = cv_n;
        prev_rd = rd_n;
    end

    // Behavioural reference
    logic e_cv, e_cs, e_cs2, e_rd, e_busy, e_done, e_err, e_vld;
    int e_ch, mfr = 0;
    logic [15:0] e_dat;

    task automatic run_frame(input bit lng);
        bit got;
        mfr++;
        e_busy = 1; e_cv = 0;
        repeat (lng ? ACQ_C : PUL_C) @(posedge clk);
        e_cv = 1;
        repeat (ARM_C) @(posedge clk);
        got = 0;
        for (int t = 1; t <= TO_C; t++) begin
            @(posedge clk);
            if (!eoc) begin got = 1; break; end
        end
        if (!got) begin
            e_err = 1;
            @(posedge clk);
            e_err = 0; e_busy = 0;
            return;
        end
        for (int c = 0; c < NCH; c++) begin
            e_rd = 0; e_cs = 0; e_cs2 = 0;
            repeat (SOFS + 1) @(posedge clk);
            e_vld = 1; e_ch = c; e_dat = smp(mfr, c);
            @(posedge clk);
            e_vld = 0;
            repeat (RDLO_C - SOFS - 2) @(posedge clk);
            if (c == NCH - 1) begin
                e_rd = 1; e_cs = 1; e_cs2 = 1; e_done = 1;
                @(posedge clk);
                e_done = 0; e_busy = 0;
            end else begin
                e_rd = 1; e_cs2 = 1;
                repeat (RDHI_C) @(posedge clk);
            end
        end
    endtask

    initial begin
        e_cv = 1; e_cs = 1; e_cs2 = 1; e_rd = 1;
        e_busy = 0; e_done = 0; e_err = 0; e_vld = 0; e_ch = 0; e_dat = '0;
        forever begin
            @(posedge clk);
            if (!rst && start) run_frame(long_acq);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(cv_n === e_cv, "R2/R3 convst_n", cv_n, e_cv);
            chk(rd_n === e_rd, "R4/R5/R11 rd_n", rd_n, e_rd);
            chk(cs_n === e_cs, "R6 cs_n held", cs_n, e_cs);
            chk(cs2 === e_cs2, "R6 cs_n toggled", cs2, e_cs2);
            chk(rd2 === e_rd, "R5 rd_n second", rd2, e_rd);
            chk(bsy === e_busy, "R9 busy", bsy, e_busy);
            chk(done === e_done, "R8 frame_done", done, e_done);
            chk(err === e_err, "R10 timeout_err", err, e_err);
            chk(vld === e_vld, "R7 res_valid", vld, e_vld);
            chk(vld2 === e_vld, "R7 res_valid second", vld2, e_vld);
            if (e_vld) begin
                chk(int'(ch) == e_ch, "R7 res_ch", ch, e_ch);
                chk(dat === e_dat, "R7 res_data", dat, e_dat);
                chk(dat2 === e_dat, "R7 res_data second", dat2, e_dat);
            end
        end
    end

    task automatic one_frame(input bit lng, input int clen);
        conv_len = clen;
        @(negedge clk); start = 1; long_acq = lng;
        @(negedge clk); start = 0;
        while (bsy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        int dc;
        rst = 1; start = 0; long_acq = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(cv_n && cs_n && rd_n && cs2, "R1 strobes high", {cv_n, cs_n, rd_n}, 3'b111);
        chk(!bsy && !vld && !done && !err, "R1 status low", {bsy, vld, done, err}, 0);
        rst = 0;
        repeat (2) @(negedge clk);

        one_frame(1'b1, 4);   // R2 long window
        one_frame(1'b0, 2);   // R3 short pulse
        one_frame(1'b0, 1);   // R4 flag falls on first trusted edge

        // R9: repeated start requests during a frame
        conv_len = 5;
        @(negedge clk); start = 1; long_acq = 1;
        @(negedge clk); long_acq = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); start = i[0];
        end
        start = 0;
        while (bsy) @(negedge clk);
        repeat (2) @(negedge clk);

        // R8/R9: start held high across frame_done, back-to-back frames
        conv_len = 3;
        @(negedge clk); start = 1; long_acq = 0;
        dc = 0;
        while (dc < 2) begin
            @(negedge clk);
            if (done) dc++;
        end
        start = 0;
        while (bsy) @(negedge clk);
        repeat (2) @(negedge clk);

        // R10/R11: conversion length swept across the timeout edge
        for (int l = TO_C - 1; l <= TO_C + 4; l++) one_frame(l[0], l);
        one_frame(1'b0, 500);
        repeat (520) @(negedge clk);
        one_frame(1'b1, 3);

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule